// File: doc/BRIEF.md
# Tag Memory Write-Access Controller

This block takes already-decoded memory commands for a passive identification tag and applies them to a small register-based nonvolatile memory model. The memory has four banks: reserved, EPC, TID and user. Each request arrives as a one-cycle pulse carrying one of three operations: a single-word write, a block write of zero to several words, or a lock. One cycle later the block answers with a success, with an 8-bit error code, or with nothing. The caller tells the block whether the tag is in the secured state. A combinational read port lets the surrounding logic observe any bank word.

Reserved word 4 is the configuration word. Only three of its bits are live. Bit 2 is the memory-map bit, which can be written once. Bit 1 is the short-range bit. Bit 0 disables tuning. The memory-map bit also sets how large the EPC and user banks are. Once that bit has changed, or once any lock has been accepted, the map is frozen.

Top module: `tag_wr_ctrl`

## Requirements
- R1: A write (req_op=0) of one word at a valid, unlocked address stores req_data[31:16] and returns, on the cycle after the request, rsp_valid=1, rsp_err=0 and rsp_code=0x00.
- R2: A block write (req_op=1) of one word is accepted at any pointer. A block write of two words at an even pointer stores req_data[31:16] at the pointer and req_data[15:0] at the pointer plus one.
- R3: A block write of two words at an odd pointer, or of more than two words, returns error code 0x00 and changes no stored word.
- R4: A block write whose word count is zero produces no reply.
- R5: Reserved word 4 reads as bit 2 = map, bit 1 = short range, bit 0 = tuning disable, with all other bits 0. Every other payload bit written to it is dropped.
- R6: The configuration word changes only in the secured state and only through a single-word write. From the open state the reply is 0x04. A two-word block write that covers word 4 returns 0x00.
- R7: The map bit resets to 1. The first write that changes it sets map_frozen, and so does any accepted lock. While map_frozen is set, the map bit no longer changes.
- R8: With map=1 the EPC bank has 10 words and the user bank 2 words. With map=0 the EPC bank has 8 words and the user bank 4 words.
- R9: Any write to the TID bank (bank 2) returns 0x04, and the fixed TID contents stay as they are.
- R10: Lock (req_op=2) is accepted only in the secured state; from the open state it returns 0x00 and changes nothing. req_lock bit 0 locks the kill words (reserved words 0-1), bit 1 the rest of the reserved bank, bit 2 the EPC bank and bit 3 the user bank. A write to a locked area from the open state returns 0x04. The same write from the secured state is accepted.
- R11: While the reserved lock (bit 1) is set, the tuning-disable bit keeps its value. Reserved word 20, the tuning value, is never writable and returns 0x00.
- R12: A write that reaches past the active size of its bank returns 0x03 and leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| secured | input | 1 | Tag is in the secured state |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 0 write, 1 block write, 2 lock |
| req_bank | input | 2 | 0 reserved, 1 EPC, 2 TID, 3 user |
| req_ptr | input | 8 | Word pointer |
| req_cnt | input | 4 | Block-write word count |
| req_data | input | 32 | First word in [31:16], second word in [15:0] |
| req_lock | input | 4 | Areas to lock |
| rsp_valid | output | 1 | Reply strobe |
| rsp_err | output | 1 | Reply is an error |
| rsp_code | output | 8 | Error code, 0x00 on success |
| rd_bank | input | 2 | Read-port bank |
| rd_ptr | input | 8 | Read-port word pointer |
| rd_data | output | 16 | Read-port word |
| map_m | output | 1 | Memory-map bit |
| short_rng | output | 1 | Short-range bit |
| tune_off | output | 1 | Tuning-disable bit |
| map_frozen | output | 1 | Memory map can no longer change |

## Verification
The properties assume a request strobe lasts one cycle. They also assume that secured and the request fields are steady while req_valid is high. The stimulus drives every request for a single cycle on the falling edge and changes secured only between requests. Two lock cases are covered, the direct lock and the lock that freezes the map, and these need different map histories. For that reason the stimulus applies a second reset partway through instead of overlapping them.

// File: rtl/tag_wr_ctrl.sv
module tag_wr_ctrl #(
  parameter int PTR_W     = 8,
  parameter int RSV_WORDS = 21,
  parameter int EPC_BIG   = 10,
  parameter int EPC_SMALL = 8,
  parameter int USR_SMALL = 2,
  parameter int USR_BIG   = 4,
  parameter int TID_WORDS = 6,
  parameter int CFG_WORD  = 4,
  parameter int TUNE_WORD = 20,
  parameter logic [2:0] TUNE_VAL = 3'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             secured,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [1:0]       req_bank,
  input  logic [PTR_W-1:0] req_ptr,
  input  logic [3:0]       req_cnt,
  input  logic [31:0]      req_data,
  input  logic [3:0]       req_lock,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [7:0]       rsp_code,
  input  logic [1:0]       rd_bank,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [15:0]      rd_data,
  output logic             map_m,
  output logic             short_rng,
  output logic             tune_off,
  output logic             map_frozen
);
  localparam int PW     = PTR_W + 1;
  localparam int RSV_AW = $clog2(RSV_WORDS);
  localparam int EPC_AW = $clog2(EPC_BIG);
  localparam int USR_AW = $clog2(USR_BIG);
  localparam logic [7:0] E_OTHER = 8'h00;
  localparam logic [7:0] E_OVER  = 8'h03;
  localparam logic [7:0] E_LOCK  = 8'h04;

  logic [15:0] rsv_q [RSV_WORDS];
  logic [15:0] epc_q [EPC_BIG];
  logic [15:0] usr_q [USR_BIG];
  logic [3:0]  lk_q;

  wire is_wr = req_op == 2'd0;
  wire is_bw = req_op == 2'd1;
  wire is_lk = req_op == 2'd2;
  wire [PW-1:0] nwords  = is_wr ? PW'(1) : PW'(req_cnt);
  wire [PW-1:0] ptr_x   = PW'(req_ptr);
  wire [PW-1:0] last    = ptr_x + nwords - PW'(1);
  wire [PTR_W-1:0] ptr1 = req_ptr + PTR_W'(1);
  wire [15:0] d0 = req_data[31:16];
  wire [15:0] d1 = req_data[15:0];

  wire [PW-1:0] epc_size = map_m ? PW'(EPC_BIG) : PW'(EPC_SMALL);
  wire [PW-1:0] usr_size = map_m ? PW'(USR_SMALL) : PW'(USR_BIG);

  function automatic logic [15:0] tid_word(input logic [PTR_W-1:0] i);
    return (i == '0) ? 16'hE280 : (16'hA000 | 16'(i));
  endfunction

  logic [PW-1:0] bank_size;
  always_comb begin
    case (req_bank)
      2'd0:    bank_size = PW'(RSV_WORDS);
      2'd1:    bank_size = epc_size;
      2'd2:    bank_size = PW'(TID_WORDS);
      default: bank_size = usr_size;
    endcase
  end

  wire fmt_bad   = is_bw && ((req_cnt > 4'd2) || (req_cnt == 4'd2 && req_ptr[0]));
  wire silent    = (is_bw && req_cnt == 4'd0) || req_op == 2'd3;
  wire in_rsv    = req_bank == 2'd0;
  wire hits_cfg  = in_rsv && ptr_x <= PW'(CFG_WORD) && last >= PW'(CFG_WORD);
  wire hits_tune = in_rsv && ptr_x <= PW'(TUNE_WORD) && last >= PW'(TUNE_WORD);

  logic area_lk;
  always_comb begin
    case (req_bank)
      2'd0:    area_lk = (req_ptr < PTR_W'(2)) ? lk_q[0] : lk_q[1];
      2'd1:    area_lk = lk_q[2];
      2'd3:    area_lk = lk_q[3];
      default: area_lk = 1'b1;
    endcase
  end

  logic       ok;
  logic [7:0] code;
  always_comb begin
    ok = 1'b0;
    code = E_OTHER;
    if (is_lk) begin
      ok = secured;
    end else if (fmt_bad) begin
      code = E_OTHER;
    end else if (req_bank == 2'd2) begin
      code = E_LOCK;
    end else if (last >= bank_size) begin
      code = E_OVER;
    end else if (hits_tune) begin
      code = E_OTHER;
    end else if (hits_cfg && nwords != PW'(1)) begin
      code = E_OTHER;
    end else if (hits_cfg && !secured) begin
      code = E_LOCK;
    end else if (area_lk && !secured) begin
      code = E_LOCK;
    end else begin
      ok = 1'b1;
    end
  end

  wire commit = req_valid && !silent && ok && !is_lk;
  wire two    = nwords == PW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_code  <= 8'h00;
    end else begin
      rsp_valid <= req_valid && !silent;
      rsp_err   <= req_valid && !silent && !ok;
      rsp_code  <= (req_valid && !silent && !ok) ? code : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_m      <= 1'b1;
      short_rng  <= 1'b0;
      tune_off   <= 1'b0;
      map_frozen <= 1'b0;
      lk_q       <= '0;
    end else if (req_valid && !silent && ok) begin
      if (is_lk) begin
        lk_q       <= lk_q | req_lock;
        map_frozen <= 1'b1;
      end else if (hits_cfg) begin
        short_rng <= d0[1];
        if (!lk_q[1]) tune_off <= d0[0];
        if (!map_frozen) begin
          map_m <= d0[2];
          if (d0[2] != map_m) map_frozen <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RSV_WORDS; i++) rsv_q[i] <= '0;
      for (int i = 0; i < EPC_BIG; i++)   epc_q[i] <= '0;
      for (int i = 0; i < USR_BIG; i++)   usr_q[i] <= '0;
    end else if (commit && !hits_cfg) begin
      case (req_bank)
        2'd0: begin
          rsv_q[req_ptr[RSV_AW-1:0]] <= d0;
          if (two) rsv_q[ptr1[RSV_AW-1:0]] <= d1;
        end
        2'd1: begin
          epc_q[req_ptr[EPC_AW-1:0]] <= d0;
          if (two) epc_q[ptr1[EPC_AW-1:0]] <= d1;
        end
        2'd3: begin
          usr_q[req_ptr[USR_AW-1:0]] <= d0;
          if (two) usr_q[ptr1[USR_AW-1:0]] <= d1;
        end
        default: ;
      endcase
    end
  end

  wire [PW-1:0] rd_x = PW'(rd_ptr);
  always_comb begin
    rd_data = 16'h0000;
    case (rd_bank)
      2'd0: begin
        if (rd_x == PW'(CFG_WORD))       rd_data = {13'b0, map_m, short_rng, tune_off};
        else if (rd_x == PW'(TUNE_WORD)) rd_data = {13'b0, TUNE_VAL};
        else if (rd_x < PW'(RSV_WORDS))  rd_data = rsv_q[rd_ptr[RSV_AW-1:0]];
      end
      2'd1: if (rd_x < epc_size) rd_data = epc_q[rd_ptr[EPC_AW-1:0]];
      2'd2: if (rd_x < PW'(TID_WORDS)) rd_data = tid_word(rd_ptr);
      default: if (rd_x < usr_size) rd_data = usr_q[rd_ptr[USR_AW-1:0]];
    endcase
  end
endmodule

module tag_wr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       secured,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic [1:0] req_bank,
  input logic [7:0] req_ptr,
  input logic [3:0] req_cnt,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic [7:0] rsp_code,
  input logic       map_m,
  input logic       short_rng,
  input logic       map_frozen
);
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd1 && req_cnt == 4'd0 |=> !rsp_valid); // R4
  AST_ODD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd1 && req_cnt == 4'd2 && req_ptr[0]
    |=> rsp_valid && rsp_err && rsp_code == 8'h00); // R3
  AST_REPLY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R1
  AST_TID_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_bank == 2'd2 && (req_op == 2'd0 || (req_op == 2'd1 && req_cnt != 4'd0))
    |=> rsp_valid && rsp_err); // R9
  AST_MAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    map_frozen |=> map_frozen && $stable(map_m)); // R7
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd2 && secured |=> map_frozen); // R7
  AST_OPEN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !secured && req_op == 2'd0 && req_bank == 2'd0 && req_ptr == 8'd4
    |=> $stable(short_rng) && rsp_code == 8'h04); // R6
endmodule

bind tag_wr_ctrl tag_wr_ctrl_chk u_chk (.*);

// File: tb/sim_tag_wr_ctrl.sv
module sim_tag_wr_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, secured = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0, req_bank = '0;
  logic [7:0] req_ptr = '0;
  logic [3:0] req_cnt = '0;
  logic [31:0] req_data = '0;
  logic [3:0] req_lock = '0;
  logic rsp_valid, rsp_err, map_m, short_rng, tune_off, map_frozen;
  logic [7:0] rsp_code;
  logic [1:0] rd_bank = '0;
  logic [7:0] rd_ptr = '0;
  logic [15:0] rd_data;
  int vecs = 0, miss = 0;

  typedef struct {bit rep; bit err; logic [7:0] code; string tag;} exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  tag_wr_ctrl u0 (.*);

  task automatic issue(input logic [1:0] op, input logic [1:0] bank, input logic [7:0] ptr,
                       input logic [3:0] cnt, input logic [31:0] data, input logic [3:0] lk,
                       input bit rep, input bit err, input logic [7:0] code, input string tag);
    exp_t e;
    @(negedge clk);
    e.rep = rep; e.err = err; e.code = code; e.tag = tag;
    q.push_back(e);
    req_op = op; req_bank = bank; req_ptr = ptr; req_cnt = cnt;
    req_data = data; req_lock = lk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial forever begin
    @(posedge clk); #1;
    if (req_valid) begin
      exp_t e;
      e = q.pop_front();
      vecs++;
      if (rsp_valid != e.rep || (e.rep && (rsp_err != e.err || rsp_code != e.code))) begin
        miss++;
        $display("FAIL %s: reply v=%0b e=%0b c=%02h expected v=%0b e=%0b c=%02h",
                 e.tag, rsp_valid, rsp_err, rsp_code, e.rep, e.err, e.code);
      end
    end else if (rst_n && rsp_valid) begin
      miss++;
      $display("FAIL R4: reply with no request, actual v=1 expected v=0");
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %04h expected %04h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] bank, input logic [7:0] ptr, input logic [15:0] exp,
                    input string tag);
    @(negedge clk);
    rd_bank = bank; rd_ptr = ptr;
    #1 chk(rd_data, exp, tag);
  endtask

  task automatic set_sec(input logic s);
    @(negedge clk);
    secured = s;
  endtask

  initial begin
    #(200000 * 4);
    miss++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({12'b0, rsp_valid, map_m, short_rng, map_frozen}, 16'h0004, "R7 reset state");
    rst_n = 1'b1;
    // R1 single write
    issue(0, 1, 2, 0, 32'hA5A5_0000, 0, 1, 0, 8'h00, "R1 write");
    rd(1, 2, 16'hA5A5, "R1 stored");
    // R2 block writes
    issue(1, 1, 3, 1, 32'h3333_0000, 0, 1, 0, 8'h00, "R2 one word odd ptr");
    issue(1, 1, 4, 2, 32'h1111_2222, 0, 1, 0, 8'h00, "R2 two words even");
    rd(1, 3, 16'h3333, "R2 word3");
    rd(1, 4, 16'h1111, "R2 word4");
    rd(1, 5, 16'h2222, "R2 word5");
    // R3 format errors
    issue(1, 1, 5, 2, 32'hDEAD_BEEF, 0, 1, 1, 8'h00, "R3 odd pair");
    rd(1, 5, 16'h2222, "R3 unchanged");
    issue(1, 1, 6, 3, 32'hDEAD_BEEF, 0, 1, 1, 8'h00, "R3 three words");
    rd(1, 6, 16'h0000, "R3 unchanged 6");
    // R4 zero count
    issue(1, 1, 2, 0, 32'h0, 0, 0, 0, 8'h00, "R4 zero words");
    // R12 overrun
    issue(0, 1, 10, 0, 32'h7777_0000, 0, 1, 1, 8'h03, "R12 EPC overrun");
    issue(0, 3, 2, 0, 32'h7777_0000, 0, 1, 1, 8'h03, "R12 user overrun");
    rd(3, 2, 16'h0000, "R12 user unchanged");
    // R9 TID
    issue(0, 2, 0, 0, 32'h0000_0000, 0, 1, 1, 8'h04, "R9 TID write");
    issue(1, 2, 2, 2, 32'h0000_0000, 0, 1, 1, 8'h04, "R9 TID block");
    rd(2, 0, 16'hE280, "R9 TID intact");
    // R5 configuration word
    issue(0, 0, 4, 0, 32'hFFF6_0000, 0, 1, 0, 8'h00, "R5 cfg write");
    rd(0, 4, 16'h0006, "R5 cfg readback");
    chk({15'b0, map_frozen}, 16'h0000, "R7 no freeze when M same");
    // R6 open state / multi-word
    set_sec(0);
    issue(0, 0, 4, 0, 32'h0000_0000, 0, 1, 1, 8'h04, "R6 open cfg");
    rd(0, 4, 16'h0006, "R6 cfg unchanged");
    set_sec(1);
    issue(1, 0, 4, 2, 32'h0000_0000, 0, 1, 1, 8'h00, "R6 two-word cfg");
    // R7/R8 map change
    issue(0, 0, 4, 0, 32'h0000_0000, 0, 1, 0, 8'h00, "R7 map to 0");
    chk({14'b0, map_m, map_frozen}, 16'h0001, "R7 map written frozen");
    issue(0, 3, 3, 0, 32'h4444_0000, 0, 1, 0, 8'h00, "R8 user word 3");
    rd(3, 3, 16'h4444, "R8 user word 3 stored");
    issue(0, 1, 8, 0, 32'h5555_0000, 0, 1, 1, 8'h03, "R8 EPC word 8 gone");
    issue(0, 0, 4, 0, 32'h0004_0000, 0, 1, 0, 8'h00, "R7 rewrite map");
    rd(0, 4, 16'h0000, "R7 map held at 0");
    // R11 tuning word
    issue(0, 0, 20, 0, 32'h0007_0000, 0, 1, 1, 8'h00, "R11 tune word");
    rd(0, 20, 16'h0002, "R11 tune intact");
    // R10 locks
    set_sec(0);
    issue(2, 0, 0, 0, 32'h0, 4'b0110, 1, 1, 8'h00, "R10 open lock");
    issue(0, 1, 2, 0, 32'h6666_0000, 0, 1, 0, 8'h00, "R10 open write unlocked");
    set_sec(1);
    issue(2, 0, 0, 0, 32'h0, 4'b0110, 1, 0, 8'h00, "R10 lock");
    set_sec(0);
    issue(0, 1, 2, 0, 32'h9999_0000, 0, 1, 1, 8'h04, "R10 EPC locked");
    rd(1, 2, 16'h6666, "R10 EPC unchanged");
    issue(0, 3, 0, 0, 32'h8888_0000, 0, 1, 0, 8'h00, "R10 user open");
    issue(0, 0, 0, 0, 32'h1234_0000, 0, 1, 0, 8'h00, "R10 kill open");
    issue(0, 0, 2, 0, 32'h1234_0000, 0, 1, 1, 8'h04, "R10 access locked");
    set_sec(1);
    issue(0, 1, 2, 0, 32'h9999_0000, 0, 1, 0, 8'h00, "R10 secured write");
    rd(1, 2, 16'h9999, "R10 secured stored");
    issue(0, 0, 4, 0, 32'h0003_0000, 0, 1, 0, 8'h00, "R11 A held");
    rd(0, 4, 16'h0002, "R11 A still 0, S set");
    // R7 lock freezes map
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    issue(2, 0, 0, 0, 32'h0, 4'b0000, 1, 0, 8'h00, "R7 empty lock");
    chk({15'b0, map_frozen}, 16'h0001, "R7 lock froze map");
    issue(0, 0, 4, 0, 32'h0000_0000, 0, 1, 0, 8'h00, "R7 write after lock");
    rd(0, 4, 16'h0004, "R7 map stays 1");
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule